// File: doc/BRIEF.md
# Link Flit Inversion Decoder with Gray-to-Binary Recovery

This block sits at the receiving end of an on-chip network link. The sender first converts each payload word from binary to Gray code. It may then invert part or all of the word to cut switching and coupling activity on the wires. The receiver gets the encoded payload and a small inversion-mode code that travels with it. It reverses the inversion the code selects, then turns the Gray word back into the original binary value. The routers and links in between do not change.

Header flits are never encoded. A header marker travels with each flit, and a marked flit goes through the block untouched. A parameter selects the mode format. The single-flag format only knows "no inversion" and "odd-position inversion". The two-bit format also has even-position inversion and full inversion. The result is registered, so each flit takes one clock cycle to get through.

Top module: `link_flit_decoder`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid`, `out_header` and `out_data` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock cycle earlier.
- R3: A valid payload flit with mode code 00 is not inverted. `out_data` is the Gray-to-binary conversion of `in_payload`.
- R4: In the two-bit format, mode code 10 inverts the bits at odd index positions (1, 3, 5, ...) before conversion.
- R5: In the two-bit format, mode code 01 inverts the bits at even index positions (0, 2, 4, ...) before conversion.
- R6: In the two-bit format, mode code 11 inverts every payload bit before conversion.
- R7: Gray-to-binary conversion: the top output bit equals the top restored bit. Each lower output bit is the XOR of the output bit just above it and its own restored bit.
- R8: A valid flit with `in_header` high appears one cycle later on `out_data` exactly as `in_payload`, whatever the mode code is, with `out_header` high.
- R9: In the single-flag format (MODE_FMT=0), `in_mode[0]`=1 selects odd-position inversion and 0 selects none. `in_mode[1]` has no effect.
- R10: In a cycle with `in_valid` low, `out_data` and `out_header` keep their previous values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit qualifier |
| in_header | input | 1 | Marks an unencoded header flit |
| in_payload | input | PAYLOAD_W | Encoded payload word from the link |
| in_mode | input | 2 | Inversion mode code |
| out_valid | output | 1 | Registered flit qualifier |
| out_header | output | 1 | Registered header marker |
| out_data | output | PAYLOAD_W | Recovered binary payload |

## Verification
The only internal state is the output register, so any fault in it shows up on the ports in the very next cycle. A wrong mask selection or a swapped odd/even pattern gives a wrong binary value one cycle after the flit. A break in the Gray chain corrupts every bit below the faulty position. A capture enable that ignores `in_valid` changes held data during idle cycles. That error is visible in the first idle cycle after a flit. The bench sweeps every payload value under every mode code in both formats, so each of these faults produces a mismatch.

// File: rtl/flit_dec_pkg.sv
package flit_dec_pkg;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_EVEN = 2'b01,
        INV_ODD  = 2'b10,
        INV_FULL = 2'b11
    } inv_mode_e;

    localparam int FMT_FLAG  = 0;
    localparam int FMT_QUAD  = 1;

endpackage

// File: rtl/inv_mask_sel.sv
module inv_mask_sel
    import flit_dec_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int MODE_FMT  = FMT_QUAD
) (
    input  logic [1:0]           mode_code,
    output logic [PAYLOAD_W-1:0] mask
);

    logic [PAYLOAD_W-1:0] odd_pat;
    logic [PAYLOAD_W-1:0] even_pat;

    for (genvar b = 0; b < PAYLOAD_W; b++) begin : g_pat
        assign odd_pat[b]  = (b % 2) == 1;
        assign even_pat[b] = (b % 2) == 0;
    end

    if (MODE_FMT == FMT_QUAD) begin : g_quad
        inv_mode_e sel;
        assign sel = inv_mode_e'(mode_code);
        always_comb begin
            unique case (sel)
                INV_ODD:  mask = odd_pat;
                INV_EVEN: mask = even_pat;
                INV_FULL: mask = '1;
                default:  mask = '0;
            endcase
        end
    end else begin : g_flag
        logic unused_mode_hi;
        logic unused_even;
        assign unused_mode_hi = mode_code[1];
        assign unused_even    = ^even_pat;
        assign mask = mode_code[0] ? odd_pat : '0;
    end

endmodule

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign bin_out[b] = ^gray_in[WIDTH-1:b];
    end

endmodule

// File: rtl/link_flit_decoder.sv
module link_flit_decoder
    import flit_dec_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int MODE_FMT  = FMT_QUAD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_header,
    input  logic [PAYLOAD_W-1:0] in_payload,
    input  logic [1:0]           in_mode,
    output logic                 out_valid,
    output logic                 out_header,
    output logic [PAYLOAD_W-1:0] out_data
);

    typedef struct packed {
        logic                 valid;
        logic                 header;
        logic [PAYLOAD_W-1:0] data;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    logic [PAYLOAD_W-1:0] inv_mask;
    logic [PAYLOAD_W-1:0] restored_gray;
    logic [PAYLOAD_W-1:0] recovered_bin;

    inv_mask_sel #(
        .PAYLOAD_W (PAYLOAD_W),
        .MODE_FMT  (MODE_FMT)
    ) u_mask (
        .mode_code (in_mode),
        .mask      (inv_mask)
    );

    assign restored_gray = in_payload ^ inv_mask;

    gray_to_bin #(
        .WIDTH (PAYLOAD_W)
    ) u_g2b (
        .gray_in (restored_gray),
        .bin_out (recovered_bin)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.header = in_header;
            state_d.data   = in_header ? in_payload : recovered_bin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign out_header = state_q.header;
    assign out_data   = state_q.data;

endmodule

// File: rtl/link_flit_decoder_chk.sv
module link_flit_decoder_chk #(
    parameter int PAYLOAD_W = 8,
    parameter int MODE_FMT  = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_header,
    input logic [PAYLOAD_W-1:0] in_payload,
    input logic [1:0]           in_mode,
    input logic                 out_valid,
    input logic                 out_header,
    input logic [PAYLOAD_W-1:0] out_data
);

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_header)));

    assert_header_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_header) |=> (out_header && out_data == $past(in_payload)));

    assert_payload_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_header) |=> !out_header);

    assert_plain_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_header && in_mode == 2'b00)
        |=> out_data[PAYLOAD_W-1] == $past(in_payload[PAYLOAD_W-1]));

    assert_full_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_FMT == 1 && in_valid && !in_header && in_mode == 2'b11)
        |=> out_data[PAYLOAD_W-1] != $past(in_payload[PAYLOAD_W-1]));

endmodule

bind link_flit_decoder link_flit_decoder_chk #(
    .PAYLOAD_W (PAYLOAD_W),
    .MODE_FMT  (MODE_FMT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_header  (in_header),
    .in_payload (in_payload),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_header (out_header),
    .out_data   (out_data)
);

// File: tb/sim_link_flit_decoder.sv
module sim_link_flit_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         v0 = 1'b0, h0 = 1'b0, v1 = 1'b0, h1 = 1'b0;
    logic [W-1:0] p0 = '0, p1 = '0;
    logic [1:0]   m0 = '0, m1 = '0;
    logic         ov0, oh0, ov1, oh1;
    logic [W-1:0] od0, od1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_flit_decoder #(.PAYLOAD_W(W), .MODE_FMT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_header(h0),
        .in_payload(p0), .in_mode(m0),
        .out_valid(ov0), .out_header(oh0), .out_data(od0));

    link_flit_decoder #(.PAYLOAD_W(W), .MODE_FMT(0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_header(h1),
        .in_payload(p1), .in_mode(m1),
        .out_valid(ov1), .out_header(oh1), .out_data(od1));

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // masks from the requirements: odd = indices 1,3,..; even = 0,2,..
    function automatic logic [W-1:0] quad_mask(input logic [1:0] m);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W; i++) begin
            case (m)
                2'b10: r[i] = (i % 2 == 1);
                2'b01: r[i] = (i % 2 == 0);
                2'b11: r[i] = 1'b1;
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset u0", {ov0, oh0, od0}, '0);
        check("R1 reset u1", {ov1, oh1, od1}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset u0", {ov0, oh0, od0}, '0);

        // R3..R7: sweep all data under all modes, two-bit format
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < (1 << W); d++) begin
                v0 = 1'b1; h0 = 1'b0; m0 = 2'(m);
                p0 = to_gray(W'(d)) ^ quad_mask(2'(m));
                @(negedge clk);
                case (m)
                    0: check("R3 R7 none", {ov0, oh0, od0}, {2'b10, W'(d)});
                    1: check("R5 R7 even", {ov0, oh0, od0}, {2'b10, W'(d)});
                    2: check("R4 R7 odd",  {ov0, oh0, od0}, {2'b10, W'(d)});
                    default: check("R6 R7 full", {ov0, oh0, od0}, {2'b10, W'(d)});
                endcase
            end
        end

        // R8: header flits pass unchanged under every mode
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < (1 << W); d += 37) begin
                v0 = 1'b1; h0 = 1'b1; m0 = 2'(m); p0 = W'(d);
                @(negedge clk);
                check("R8 header", {ov0, oh0, od0}, {2'b11, W'(d)});
            end
        end

        // R2 and R10: idle gap holds data, valid follows
        v0 = 1'b1; h0 = 1'b0; m0 = 2'b00; p0 = to_gray(8'h5C);
        @(negedge clk);
        held = od0;
        check("R3 before gap", {ov0, oh0, od0}, {2'b10, 8'h5C});
        v0 = 1'b0; h0 = 1'b1; m0 = 2'b11; p0 = 8'hFF;
        @(negedge clk);
        check("R2 R10 idle", {ov0, oh0, od0}, {2'b00, held});
        @(negedge clk);
        check("R10 idle twice", {ov0, oh0, od0}, {2'b00, held});
        v0 = 1'b1; h0 = 1'b0; m0 = 2'b10; p0 = to_gray(8'h01) ^ quad_mask(2'b10);
        @(negedge clk);
        check("R2 resume", {ov0, oh0, od0}, {2'b10, 8'h01});
        v0 = 1'b0;

        // R9: single-flag format, in_mode[1] toggled to show no effect
        for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < (1 << W); d++) begin
                v1 = 1'b1; h1 = 1'b0; m1 = 2'(f);
                p1 = to_gray(W'(d)) ^ (f[0] ? quad_mask(2'b10) : '0);
                @(negedge clk);
                check("R9 flag", {ov1, oh1, od1}, {2'b10, W'(d)});
            end
        end
        v1 = 1'b1; h1 = 1'b1; m1 = 2'b11; p1 = 8'hA7;
        @(negedge clk);
        check("R8 header flag fmt", {ov1, oh1, od1}, {2'b11, 8'hA7});
        v1 = 1'b0;
        @(negedge clk);
        check("R2 R10 flag idle", {ov1, oh1, od1}, {2'b01, 8'hA7});

        finish_run();
    end

endmodule